// File: doc/BRIEF.md
# Dual-Lane Toggle-Bit Completion Poller

This block runs on the host side of a flash interface. After software has started a program or erase operation on two byte-wide flash devices that share one 16-bit data path, the poller decides whether the operation has finished and whether it worked. It reads the status word in pairs and compares the toggle bit of each byte lane between the two reads of a pair. A lane whose toggle bit holds still has completed. A lane that is still toggling is watched for its timing-limit flag. Once that flag is set, one more pair of reads settles the matter: the lane passes if the toggling has stopped and fails if it has not.

Each lane keeps its own verdict. A lane that has settled ignores later reads while the other lane is still being polled. A programmable ceiling on the number of read pairs forces any unsettled lane to fail. If any lane fails, the poller writes the reset command to the bus so that the devices return to array read mode. It then gives a single done pulse, along with per-lane and overall pass results.

Top module: `toggle_poll_engine`

## Requirements
- R1: After reset, `rd_req`, `wr_req` and `done` are low, and `lane_pass` and `pass` read 0.
- R2: Reads are issued with `rd_req` held high until the cycle in which `bus_ack` is high. Only one request is outstanding at a time, and `rd_req` and `wr_req` are never high together. Each poll round consists of exactly two reads.
- R3: In lane k the toggle bit is bit 6 of byte k (lane 0 on `rd_data[7:0]`, lane 1 on `rd_data[15:8]`). A lane in normal polling whose toggle bit is equal in both reads of a pair is resolved as passed.
- R4: In lane k the timing-limit bit is bit 5 of byte k, taken from the second read of the pair. A lane whose toggle bit differs while this bit is 0 stays unresolved, and another pair of reads follows.
- R5: A lane whose toggle bit differs while the timing-limit bit is 1 enters confirmation. After the next pair, the lane passes if its toggle bit is equal across that pair and fails if the toggle bit still differs.
- R6: The two lanes are judged independently. A resolved lane keeps its verdict while the other lane continues to be polled.
- R7: When the number of evaluated pairs reaches `max_polls` (0 counts as 1), every lane that is still unresolved is resolved as failed.
- R8: If any lane fails, exactly one write is issued before `done`, with `wr_data` carrying the reset command 0xF0 in every byte lane. When both lanes pass, no write is issued.
- R9: `done` is a single-cycle pulse given only after both lanes are resolved. `pass` is the AND of the `lane_pass` bits, and all results hold until the next accepted start.
- R10: A `start` pulse that arrives while a poll is in progress is ignored. The read count and the results are the same as without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling (accepted only when idle) |
| max_polls | input | 8 | Maximum number of read pairs |
| rd_req | output | 1 | Read request, held until acknowledged |
| wr_req | output | 1 | Write request for the reset command |
| wr_data | output | 16 | Write data (reset command in each lane) |
| bus_ack | input | 1 | Bus acknowledge for the current request |
| rd_data | input | 16 | Read data, valid in the acknowledge cycle |
| done | output | 1 | One-cycle completion pulse |
| lane_pass | output | 2 | Per-lane pass result |
| pass | output | 1 | Both lanes passed |

## Verification
The assertions assume that `bus_ack` is high only while a request is pending and for a single cycle per request, and that `rd_data` is valid in that cycle. The bench's device model holds to this. It acknowledges each request once, on a negative edge, and drops `bus_ack` on the following negative edge before it serves another request. The status bytes are generated from the read index. The toggle bit alternates until a chosen stop index and then holds its last value, and the timing-limit bit rises at a chosen index. Sweeps over these indices for both lanes and over several poll ceilings reach every path of the algorithm.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
    localparam int TOG_BIT = 6;
    localparam int LIM_BIT = 5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD1,
        S_RD2,
        S_EVAL,
        S_DECIDE,
        S_RST,
        S_DONE
    } eng_e;

    typedef enum logic [1:0] {
        L_POLL,
        L_CONF,
        L_PASS,
        L_FAIL
    } lane_e;
endpackage

// File: rtl/tbp_lane_judge.sv
module tbp_lane_judge
    import tbp_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          eval,
    input  logic          abort,
    input  logic [BW-1:0] prev,
    input  logic [BW-1:0] curr,
    output logic          resolved,
    output logic          passed
);
    typedef struct packed {
        lane_e st;
    } lstate_t;

    lstate_t s_d, s_q;
    logic    toggling;

    always_comb begin
        s_d      = s_q;
        toggling = prev[TOG_BIT] ^ curr[TOG_BIT];
        if (clear) begin
            s_d.st = L_POLL;
        end else if (eval) begin
            case (s_q.st)
                L_POLL: begin
                    if (!toggling)          s_d.st = L_PASS;
                    else if (curr[LIM_BIT]) s_d.st = L_CONF;
                end
                L_CONF:  s_d.st = toggling ? L_FAIL : L_PASS;
                default: s_d.st = s_q.st;
            endcase
            if (abort && (s_d.st == L_POLL || s_d.st == L_CONF))
                s_d.st = L_FAIL;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: L_FAIL};
        else        s_q <= s_d;
    end

    assign resolved = (s_q.st == L_PASS) || (s_q.st == L_FAIL);
    assign passed   = (s_q.st == L_PASS);

    AST_LANE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (resolved && !clear) |=> $stable(s_q.st)); // R6
    AST_CONF_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == L_CONF && eval && !clear) |=> resolved); // R5
endmodule

// File: rtl/tbp_poll_counter.sv
module tbp_poll_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          inc,
    input  logic [CW-1:0] limit,
    output logic          last
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } cstate_t;

    cstate_t c_d, c_q;
    logic [CW:0] next_cnt;

    always_comb begin
        c_d      = c_q;
        next_cnt = {1'b0, c_q.cnt} + {{CW{1'b0}}, 1'b1};
        if (clear)    c_d.cnt = '0;
        else if (inc) c_d.cnt = next_cnt[CW-1:0];
    end

    assign last = (next_cnt >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{cnt: '0};
        else        c_q <= c_d;
    end

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (c_q.cnt == '0)); // R7
endmodule

// File: rtl/toggle_poll_engine.sv
module toggle_poll_engine
    import tbp_pkg::*;
#(
    parameter int          LANES   = 2,
    parameter int          LANE_W  = 8,
    parameter int          CNT_W   = 8,
    parameter logic [7:0]  RST_CMD = 8'hF0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [CNT_W-1:0]        max_polls,
    output logic                    rd_req,
    output logic                    wr_req,
    output logic [LANES*LANE_W-1:0] wr_data,
    input  logic                    bus_ack,
    input  logic [LANES*LANE_W-1:0] rd_data,
    output logic                    done,
    output logic [LANES-1:0]        lane_pass,
    output logic                    pass
);
    localparam int BUS_W = LANES * LANE_W;

    typedef struct packed {
        eng_e             st;
        logic [BUS_W-1:0] first;
        logic [BUS_W-1:0] second;
    } estate_t;

    estate_t e_d, e_q;
    logic             clear, eval, last;
    logic [LANES-1:0] resolved, passed;

    always_comb begin
        e_d    = e_q;
        rd_req = 1'b0;
        wr_req = 1'b0;
        done   = 1'b0;
        clear  = 1'b0;
        eval   = 1'b0;
        case (e_q.st)
            S_IDLE: if (start) begin
                clear  = 1'b1;
                e_d.st = S_RD1;
            end
            S_RD1: begin
                rd_req = 1'b1;
                if (bus_ack) begin
                    e_d.first = rd_data;
                    e_d.st    = S_RD2;
                end
            end
            S_RD2: begin
                rd_req = 1'b1;
                if (bus_ack) begin
                    e_d.second = rd_data;
                    e_d.st     = S_EVAL;
                end
            end
            S_EVAL: begin
                eval   = 1'b1;
                e_d.st = S_DECIDE;
            end
            S_DECIDE: begin
                if (&resolved) e_d.st = (&passed) ? S_DONE : S_RST;
                else           e_d.st = S_RD1;
            end
            S_RST: begin
                wr_req = 1'b1;
                if (bus_ack) e_d.st = S_DONE;
            end
            S_DONE: begin
                done   = 1'b1;
                e_d.st = S_IDLE;
            end
            default: e_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) e_q <= '{st: S_IDLE, first: '0, second: '0};
        else        e_q <= e_d;
    end

    tbp_poll_counter #(.CW(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .inc   (eval),
        .limit (max_polls),
        .last  (last)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        tbp_lane_judge #(.BW(LANE_W)) u_judge (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (clear),
            .eval     (eval),
            .abort    (last),
            .prev     (e_q.first[g*LANE_W +: LANE_W]),
            .curr     (e_q.second[g*LANE_W +: LANE_W]),
            .resolved (resolved[g]),
            .passed   (passed[g])
        );
    end

    assign wr_data   = wr_req ? {LANES{RST_CMD}} : '0;
    assign lane_pass = passed;
    assign pass      = &passed;

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req)); // R2
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !bus_ack) |=> rd_req); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_RESOLVED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (&resolved)); // R9
    AST_WR_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && bus_ack) |=> done); // R8
    AST_WR_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !(&passed)); // R8
endmodule

// File: tb/sim_toggle_poll_engine.sv
module sim_toggle_poll_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  max_polls = 8'd4;
    logic        rd_req, wr_req, done, pass;
    logic [15:0] wr_data;
    logic        bus_ack = 1'b0;
    logic [15:0] rd_data = '0;
    logic [1:0]  lane_pass;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int ridx, nreads, nwrites, bad_wdata;
    int stop_i [2];
    int lim_i  [2];

    always #5 clk = ~clk;

    toggle_poll_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .max_polls(max_polls),
        .rd_req(rd_req), .wr_req(wr_req), .wr_data(wr_data),
        .bus_ack(bus_ack), .rd_data(rd_data),
        .done(done), .lane_pass(lane_pass), .pass(pass)
    );

    function automatic logic tog_val(int i, int stop);
        if (i < stop) return i[0];
        if (stop == 0) return 1'b0;
        return stop[0] ^ 1'b1;
    endfunction

    function automatic logic [7:0] lane_byte(int i, int k);
        logic [7:0] b;
        b    = 8'(i * 7 + k * 3);
        b[6] = tog_val(i, stop_i[k]);
        b[5] = (i >= lim_i[k]);
        return b;
    endfunction

    always @(negedge clk) begin
        cycles++;
        if (!rst_n) begin
            bus_ack = 1'b0;
        end else if ((rd_req || wr_req) && !bus_ack) begin
            bus_ack = 1'b1;
            if (rd_req) begin
                rd_data = {lane_byte(ridx, 1), lane_byte(ridx, 0)};
                ridx++;
                nreads++;
            end else begin
                nwrites++;
                if (wr_data != 16'hF0F0) bad_wdata++;
            end
        end else begin
            bus_ack = 1'b0;
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic lane_model(int stop, int lim, int mp, output bit ok, output int pairs);
        int eff;
        bit conf;
        eff  = (mp == 0) ? 1 : mp;
        conf = 0;
        ok   = 0;
        pairs = eff;
        for (int p = 0; p < eff; p++) begin
            bit tg;
            tg = (2 * p + 1 < stop);
            if (!tg)   begin ok = 1; pairs = p + 1; return; end
            if (conf)  begin ok = 0; pairs = p + 1; return; end
            if (2 * p + 1 >= lim) conf = 1;
        end
    endtask

    task automatic run(int s0, int l0, int s1, int l1, int mp, bit poke);
        bit ok0, ok1;
        int p0, p1, pairs, wait_c;
        stop_i[0] = s0; lim_i[0] = l0;
        stop_i[1] = s1; lim_i[1] = l1;
        max_polls = 8'(mp);
        lane_model(s0, l0, mp, ok0, p0);
        lane_model(s1, l1, mp, ok1, p1);
        pairs = (p0 > p1) ? p0 : p1;
        ridx = 0; nreads = 0; nwrites = 0; bad_wdata = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_c = 0;
        while (!done && wait_c < 600) begin
            @(negedge clk);
            wait_c++;
            if (poke && wait_c == 3) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
        check(done == 1'b1, "R9", "done seen", int'(done), 1);
        check(nreads == 2 * pairs, "R2/R4/R7", "read count", nreads, 2 * pairs);
        check(lane_pass[0] == ok0, "R3/R5/R7 R6", "lane0 verdict", int'(lane_pass[0]), int'(ok0));
        check(lane_pass[1] == ok1, "R3/R5/R7 R6", "lane1 verdict", int'(lane_pass[1]), int'(ok1));
        check(pass == (ok0 && ok1), "R9", "pass is AND", int'(pass), int'(ok0 && ok1));
        check(nwrites == ((ok0 && ok1) ? 0 : 1), "R8", "reset writes", nwrites, (ok0 && ok1) ? 0 : 1);
        check(bad_wdata == 0, "R8", "reset data 0xF0 per lane", bad_wdata, 0);
        if (poke) check(nreads == 2 * pairs, "R10", "start while busy ignored", nreads, 2 * pairs);
        @(negedge clk);
        check(done == 1'b0, "R9", "done one cycle", int'(done), 0);
        repeat (3) @(negedge clk);
        check(lane_pass == {ok1, ok0}, "R9", "results held", int'(lane_pass), int'({ok1, ok0}));
        check(nreads == 2 * pairs && !rd_req, "R9", "idle after done", int'(rd_req), 0);
    endtask

    initial begin
        int lims [3];
        lims[0] = 1; lims[1] = 3; lims[2] = 99;
        stop_i[0] = 0; stop_i[1] = 0; lim_i[0] = 99; lim_i[1] = 99;
        ridx = 0; nreads = 0; nwrites = 0; bad_wdata = 0;
        repeat (3) @(negedge clk);
        check(!rd_req && !wr_req && !done, "R1", "requests idle after reset", int'({rd_req, wr_req, done}), 0);
        check(lane_pass == 2'b00 && !pass, "R1", "results clear after reset", int'(lane_pass), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int mp = 3; mp <= 5; mp += 2)
            for (int s0 = 0; s0 < 8; s0++)
                for (int li = 0; li < 3; li++)
                    run(s0, lims[li], 7 - s0, lims[2 - li], mp, 1'b0);
        // R7: ceiling of zero behaves as one pair
        run(9, 99, 0, 99, 0, 1'b0);
        // R5 fail path on one lane, pass on other
        run(20, 1, 1, 99, 6, 1'b0);
        // R10 start pulses during a busy poll
        run(6, 99, 9, 3, 6, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule